// File: doc/BRIEF.md
# Processor Status Flags Register

This block keeps the six condition and control flags of a small 8-bit processor core: carry, zero, interrupt mask, decimal, overflow and negative. The flags change on the rising clock edge from four sources. The ALU result port carries a separate write-enable for each flag. The set/clear masks serve the flag-manipulation instructions. The pull port loads a byte restored from the stack. The entry strobe fires when a software break or a hardware interrupt begins.

When the core saves the flags, the block forms the byte to write from the current flags and a source select. Bits 5 and 4 of the saved byte are not stored anywhere. They are generated at save time, and their values tell a handler whether an instruction or an interrupt line caused the save. A restore drops those two bits. The block also drives a maskable-interrupt enable to the interrupt logic and a decimal-mode enable to the ALU. A parameter can force the decimal-mode enable off while the decimal flag itself stays stored.

Top module: `status_flags_reg`

## Requirements
- R1: After a synchronous reset, `flags_q` reads 0x04: the interrupt mask is 1 and every other flag is 0.
- R2: With `push_source` = 0 (instruction), `push_byte` has bits 5 and 4 both 1, and its bits 7, 6 and 3..0 equal those of `flags_q`. The output is combinational.
- R3: With `push_source` = 1 (interrupt), `push_byte` has bit 5 = 1 and bit 4 = 0, and its other bits mirror `flags_q`.
- R4: `int_entry` sets the interrupt mask (bit 2) on the next edge and leaves every other flag unchanged. Forming a saved byte alone changes no flag.
- R5: `pull_en` loads bits 7, 6 and 3..0 of `pull_data` into the flags. Bits 5 and 4 of `flags_q` always read 0, whatever is pulled or set.
- R6: A pull in the same cycle as an ALU update, a set/clear mask or `int_entry` wins over all of them.
- R7: When its enable is high, N takes `alu_result[7]`, and Z becomes 1 exactly when `alu_result` is 0x00.
- R8: When enabled, C takes `alu_carry` and V takes `alu_ovf`. With `bit_test` high, N takes `mem_operand[7]` and V takes `mem_operand[6]`.
- R9: A flag whose enable, mask bit and entry strobe are all inactive holds its value.
- R10: `flag_set` and `flag_clr` are masks in status-byte bit positions. They override ALU updates. If both are set for the same bit, the set wins.
- R11: `irq_enable` equals the inverse of the interrupt mask (bit 2 of `flags_q`).
- R12: `decimal_en` equals the decimal flag (bit 3) when `DECIMAL_MODE` = 1, and is constant 0 when `DECIMAL_MODE` = 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst | input | 1 | Synchronous active-high reset |
| alu_result | input | 8 | ALU result byte for N/Z |
| alu_carry | input | 1 | Carry (or no-borrow) from the ALU |
| alu_ovf | input | 1 | Signed overflow from the ALU |
| bit_test | input | 1 | Take N/V from the memory operand |
| mem_operand | input | 8 | Memory operand of the bit-test operation |
| alu_we_n | input | 1 | Update N from ALU |
| alu_we_z | input | 1 | Update Z from ALU |
| alu_we_c | input | 1 | Update C from ALU |
| alu_we_v | input | 1 | Update V from ALU |
| flag_set | input | 8 | Set mask, status-byte positions |
| flag_clr | input | 8 | Clear mask, status-byte positions |
| int_entry | input | 1 | Break or interrupt entry, sets the mask |
| pull_en | input | 1 | Load flags from pulled byte |
| pull_data | input | 8 | Byte pulled from the stack |
| push_source | input | 1 | 0 = instruction save, 1 = interrupt save |
| push_byte | output | 8 | Byte to write on a save |
| flags_q | output | 8 | Registered flags, bits 5 and 4 read 0 |
| irq_enable | output | 1 | Maskable interrupts admitted |
| decimal_en | output | 1 | Decimal mode toward the ALU |

## Verification
A corrupted flag reaches `flags_q` and `push_byte` one edge after the stimulus that caused it, so every check samples one nanosecond after that edge. A wrong interrupt mask also appears on `irq_enable` in the same cycle, and a wrong decimal bit appears on `decimal_en`. A fault in the saved-byte tag bits shows combinationally as soon as `push_source` changes. A bad priority between the pull and the other sources leaves a value that differs from the pulled byte. That difference is visible on the next edge.

// File: rtl/status_flags_pkg.sv
package status_flags_pkg;
  localparam int STAT_W  = 8;
  localparam int POS_C   = 0;
  localparam int POS_Z   = 1;
  localparam int POS_I   = 2;
  localparam int POS_D   = 3;
  localparam int POS_TAG = 4;
  localparam int POS_ONE = 5;
  localparam int POS_V   = 6;
  localparam int POS_N   = 7;
  localparam logic [STAT_W-1:0] STORED_MASK = 8'hCF;
  localparam logic [STAT_W-1:0] RESET_VALUE = 8'h04;
endpackage

// File: rtl/status_alu_src.sv
module status_alu_src
  import status_flags_pkg::*;
(
  input  logic [STAT_W-1:0] alu_result,
  input  logic              alu_carry,
  input  logic              alu_ovf,
  input  logic              bit_test,
  input  logic [STAT_W-1:0] mem_operand,
  input  logic              alu_we_n,
  input  logic              alu_we_z,
  input  logic              alu_we_c,
  input  logic              alu_we_v,
  output logic [STAT_W-1:0] alu_val,
  output logic [STAT_W-1:0] alu_we
);
  always_comb begin
    alu_val = '0;
    alu_we  = '0;
    alu_val[POS_C] = alu_carry;
    alu_val[POS_Z] = (alu_result == '0);
    alu_val[POS_V] = bit_test ? mem_operand[STAT_W-2] : alu_ovf;
    alu_val[POS_N] = bit_test ? mem_operand[STAT_W-1] : alu_result[STAT_W-1];
    alu_we[POS_C]  = alu_we_c;
    alu_we[POS_Z]  = alu_we_z;
    alu_we[POS_V]  = alu_we_v;
    alu_we[POS_N]  = alu_we_n;
  end
endmodule

// File: rtl/status_next.sv
module status_next
  import status_flags_pkg::*;
(
  input  logic [STAT_W-1:0] cur,
  input  logic [STAT_W-1:0] alu_val,
  input  logic [STAT_W-1:0] alu_we,
  input  logic [STAT_W-1:0] flag_set,
  input  logic [STAT_W-1:0] flag_clr,
  input  logic              int_entry,
  input  logic              pull_en,
  input  logic [STAT_W-1:0] pull_data,
  output logic [STAT_W-1:0] nxt
);
  for (genvar b = 0; b < STAT_W; b++) begin : g_bit
    if (STORED_MASK[b]) begin : g_stored
      always_comb begin
        if (pull_en)                      nxt[b] = pull_data[b];
        else if (b == POS_I && int_entry) nxt[b] = 1'b1;
        else if (flag_set[b])             nxt[b] = 1'b1;
        else if (flag_clr[b])             nxt[b] = 1'b0;
        else if (alu_we[b])               nxt[b] = alu_val[b];
        else                              nxt[b] = cur[b];
      end
    end else begin : g_absent
      assign nxt[b] = 1'b0;
    end
  end
endmodule

// File: rtl/status_push_fmt.sv
module status_push_fmt
  import status_flags_pkg::*;
(
  input  logic [STAT_W-1:0] cur,
  input  logic              push_source,
  output logic [STAT_W-1:0] push_byte
);
  always_comb begin
    push_byte          = cur & STORED_MASK;
    push_byte[POS_ONE] = 1'b1;
    push_byte[POS_TAG] = ~push_source;
  end
endmodule

// File: rtl/status_flags_reg.sv
module status_flags_reg
  import status_flags_pkg::*;
#(
  parameter bit DECIMAL_MODE = 1'b1
) (
  input  logic              clk,
  input  logic              rst,
  input  logic [STAT_W-1:0] alu_result,
  input  logic              alu_carry,
  input  logic              alu_ovf,
  input  logic              bit_test,
  input  logic [STAT_W-1:0] mem_operand,
  input  logic              alu_we_n,
  input  logic              alu_we_z,
  input  logic              alu_we_c,
  input  logic              alu_we_v,
  input  logic [STAT_W-1:0] flag_set,
  input  logic [STAT_W-1:0] flag_clr,
  input  logic              int_entry,
  input  logic              pull_en,
  input  logic [STAT_W-1:0] pull_data,
  input  logic              push_source,
  output logic [STAT_W-1:0] push_byte,
  output logic [STAT_W-1:0] flags_q,
  output logic              irq_enable,
  output logic              decimal_en
);
  logic [STAT_W-1:0] alu_val, alu_we, nxt;

  status_alu_src u_alu_src (
    .alu_result (alu_result),
    .alu_carry  (alu_carry),
    .alu_ovf    (alu_ovf),
    .bit_test   (bit_test),
    .mem_operand(mem_operand),
    .alu_we_n   (alu_we_n),
    .alu_we_z   (alu_we_z),
    .alu_we_c   (alu_we_c),
    .alu_we_v   (alu_we_v),
    .alu_val    (alu_val),
    .alu_we     (alu_we)
  );

  status_next u_next (
    .cur      (flags_q),
    .alu_val  (alu_val),
    .alu_we   (alu_we),
    .flag_set (flag_set),
    .flag_clr (flag_clr),
    .int_entry(int_entry),
    .pull_en  (pull_en),
    .pull_data(pull_data),
    .nxt      (nxt)
  );

  always_ff @(posedge clk) begin
    if (rst) flags_q <= RESET_VALUE;
    else     flags_q <= nxt;
  end

  status_push_fmt u_push (
    .cur        (flags_q),
    .push_source(push_source),
    .push_byte  (push_byte)
  );

  assign irq_enable = ~flags_q[POS_I];

  if (DECIMAL_MODE) begin : g_dec_on
    assign decimal_en = flags_q[POS_D];
  end else begin : g_dec_off
    assign decimal_en = 1'b0;
  end
endmodule

// File: rtl/status_flags_chk.sv
module status_flags_chk (
  input logic       clk,
  input logic       rst,
  input logic       int_entry,
  input logic       pull_en,
  input logic [7:0] pull_data,
  input logic [7:0] flag_set,
  input logic [7:0] flag_clr,
  input logic       alu_we_n,
  input logic       alu_we_z,
  input logic       alu_we_c,
  input logic       alu_we_v,
  input logic       push_source,
  input logic [7:0] push_byte,
  input logic [7:0] flags_q,
  input logic       irq_enable
);
  // R1
  reset_value_chk: assert property (@(posedge clk) disable iff (rst)
    $past(rst) |-> flags_q == 8'h04);
  // R2
  push_tag_chk: assert property (@(posedge clk) disable iff (rst)
    push_byte[5] && (push_byte[4] == !push_source) && ((push_byte & 8'hCF) == flags_q));
  // R4
  entry_mask_chk: assert property (@(posedge clk) disable iff (rst)
    (int_entry && !pull_en) |=> flags_q[2]);
  // R6
  pull_wins_chk: assert property (@(posedge clk) disable iff (rst)
    pull_en |=> flags_q == ($past(pull_data) & 8'hCF));
  // R9
  idle_hold_chk: assert property (@(posedge clk) disable iff (rst)
    (!pull_en && !int_entry && flag_set == 8'h00 && flag_clr == 8'h00 &&
     !alu_we_n && !alu_we_z && !alu_we_c && !alu_we_v) |=> $stable(flags_q));
  // R11
  irq_enable_chk: assert property (@(posedge clk) disable iff (rst)
    irq_enable == !flags_q[2]);
endmodule

bind status_flags_reg status_flags_chk u_chk (
  .clk(clk), .rst(rst), .int_entry(int_entry), .pull_en(pull_en),
  .pull_data(pull_data), .flag_set(flag_set), .flag_clr(flag_clr),
  .alu_we_n(alu_we_n), .alu_we_z(alu_we_z), .alu_we_c(alu_we_c),
  .alu_we_v(alu_we_v), .push_source(push_source), .push_byte(push_byte),
  .flags_q(flags_q), .irq_enable(irq_enable)
);

// File: tb/test_status_flags_reg.sv
`timescale 1ns/100ps
module test_status_flags_reg;
  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic [7:0] alu_result = 8'h00, mem_operand = 8'h00, flag_set = 8'h00, flag_clr = 8'h00, pull_data = 8'h00;
  logic       alu_carry = 0, alu_ovf = 0, bit_test = 0, int_entry = 0, pull_en = 0, push_source = 0;
  logic       alu_we_n = 0, alu_we_z = 0, alu_we_c = 0, alu_we_v = 0;
  logic [7:0] push_byte, flags_q, push_byte_nd, flags_q_nd;
  logic       irq_enable, decimal_en, irq_enable_nd, decimal_en_nd;
  int         n_checks = 0, n_fail = 0;

  always #2.5 clk = ~clk;

  status_flags_reg i_status_flags_reg (
    .clk(clk), .rst(rst), .alu_result(alu_result), .alu_carry(alu_carry), .alu_ovf(alu_ovf),
    .bit_test(bit_test), .mem_operand(mem_operand), .alu_we_n(alu_we_n), .alu_we_z(alu_we_z),
    .alu_we_c(alu_we_c), .alu_we_v(alu_we_v), .flag_set(flag_set), .flag_clr(flag_clr),
    .int_entry(int_entry), .pull_en(pull_en), .pull_data(pull_data), .push_source(push_source),
    .push_byte(push_byte), .flags_q(flags_q), .irq_enable(irq_enable), .decimal_en(decimal_en));

  status_flags_reg #(.DECIMAL_MODE(1'b0)) i_status_flags_reg_nodec (
    .clk(clk), .rst(rst), .alu_result(alu_result), .alu_carry(alu_carry), .alu_ovf(alu_ovf),
    .bit_test(bit_test), .mem_operand(mem_operand), .alu_we_n(alu_we_n), .alu_we_z(alu_we_z),
    .alu_we_c(alu_we_c), .alu_we_v(alu_we_v), .flag_set(flag_set), .flag_clr(flag_clr),
    .int_entry(int_entry), .pull_en(pull_en), .pull_data(pull_data), .push_source(push_source),
    .push_byte(push_byte_nd), .flags_q(flags_q_nd), .irq_enable(irq_enable_nd), .decimal_en(decimal_en_nd));

  task automatic check(input string req, input logic [7:0] act, input logic [7:0] exp);
    n_checks++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual 0x%02h expected 0x%02h", req, act, exp);
    end
  endtask

  task automatic step();
    @(posedge clk); #1;
  endtask

  task automatic idle();
    alu_we_n = 0; alu_we_z = 0; alu_we_c = 0; alu_we_v = 0; bit_test = 0;
    flag_set = 8'h00; flag_clr = 8'h00; int_entry = 0; pull_en = 0;
  endtask

  task automatic t_reset();
    rst = 1; step(); step(); rst = 0; #1;
    check("R1 flags", flags_q, 8'h04);
    check("R11 irq_enable", {7'd0, irq_enable}, 8'h00);
    check("R12 decimal_en", {7'd0, decimal_en}, 8'h00);
    push_source = 0; #1; check("R2 push instr", push_byte, 8'h34);
    push_source = 1; #1; check("R3 push intr", push_byte, 8'h24);
  endtask

  task automatic t_setclr();
    flag_set = 8'h09; step(); idle();
    check("R10 set C,D", flags_q, 8'h0D);
    check("R12 decimal_en on", {7'd0, decimal_en}, 8'h01);
    check("R12 decimal_en forced off", {7'd0, decimal_en_nd}, 8'h00);
    flag_clr = 8'h04; step(); idle();
    check("R10 clear I", flags_q, 8'h09);
    check("R11 irq_enable", {7'd0, irq_enable}, 8'h01);
    flag_set = 8'h01; flag_clr = 8'h09; step(); idle();
    check("R10 set wins", flags_q, 8'h01);
    flag_set = 8'h30; step(); idle();
    check("R5 bits 5,4 not stored", flags_q, 8'h01);
  endtask

  task automatic t_alu();
    alu_we_n = 1; alu_we_z = 1; alu_result = 8'h00; step(); idle();
    check("R7 zero result", flags_q, 8'h03);
    alu_we_n = 1; alu_we_z = 1; alu_result = 8'h80; step(); idle();
    check("R7 negative result", flags_q, 8'h81);
    alu_we_z = 1; alu_result = 8'h00; step(); idle();
    check("R9 N held, Z only", flags_q, 8'h83);
    alu_we_c = 1; alu_carry = 0; step(); idle();
    check("R8 carry cleared", flags_q, 8'h82);
    alu_we_v = 1; alu_ovf = 1; step(); idle();
    check("R8 overflow", flags_q, 8'hC2);
    bit_test = 1; mem_operand = 8'h40; alu_result = 8'h05; alu_ovf = 0;
    alu_we_n = 1; alu_we_z = 1; alu_we_v = 1; step(); idle();
    check("R8 bit test", flags_q, 8'h40);
    step();
    check("R9 idle hold", flags_q, 8'h40);
  endtask

  task automatic t_push();
    push_source = 0; #1; check("R2 push instr", push_byte, 8'h70);
    push_source = 1; #1; check("R3 push intr", push_byte, 8'h60);
    step(); check("R4 push alone no change", flags_q, 8'h40);
    int_entry = 1; step(); idle();
    check("R4 entry sets I", flags_q, 8'h44);
    check("R11 masked", {7'd0, irq_enable}, 8'h00);
    check("R3 push after entry", push_byte, 8'h64);
  endtask

  task automatic t_pull();
    pull_en = 1; pull_data = 8'h30; step(); idle();
    check("R5 pull drops bits 5,4", flags_q, 8'h00);
    check("R11 unmasked", {7'd0, irq_enable}, 8'h01);
    pull_en = 1; pull_data = 8'hFF; step(); idle();
    check("R5 pull all ones", flags_q, 8'hCF);
    pull_en = 1; pull_data = 8'h02; int_entry = 1; flag_set = 8'h01;
    alu_we_n = 1; alu_we_z = 1; alu_we_c = 1; alu_we_v = 1;
    alu_result = 8'h80; alu_carry = 1; alu_ovf = 1; step(); idle();
    check("R6 pull priority", flags_q, 8'h02);
    check("R6 pull priority nodec", flags_q_nd, 8'h02);
  endtask

  initial begin
    t_reset();
    t_setclr();
    t_alu();
    t_push();
    t_pull();
    $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
    $finish;
  end

  initial begin
    #(200000 * 5);
    n_checks++; n_fail++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
    $finish;
  end
endmodule